// File: doc/BRIEF.md
# Operand Effective Address Generator

This block turns an operand request into a 24-bit memory address. Each request carries a three-bit addressing-mode code and a two-bit operand size. It also carries the current address-register value, an optional index-register value, a 16-bit and an 8-bit displacement, and an absolute address. For the two auto-modify modes the block also returns the updated address-register value with a write-back strobe. For register-direct mode it raises a flag that tells the caller no memory access is needed.

A request is taken in with a valid/ready pair. The result is held in output registers, with its own valid, until the consumer accepts it. A two-state controller orders the work. In `ST_IDLE` the block is ready for input. The transition `T_ACCEPT` (input valid while idle) loads the result registers and moves to `ST_HOLD`. In `ST_HOLD` the output is valid. The transition `T_RELEASE` (output ready while holding) returns to `ST_IDLE`. In every other case the controller stays in its current state.

Top module: `addr_calc_unit`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: A request is captured on a clock edge where `in_valid` and `in_ready` are both 1. On the next cycle `out_valid` is 1 and `in_ready` is 0. While `out_ready` is 0, `out_valid` and all result outputs stay unchanged. The cycle after `out_ready` is 1, `out_valid` is 0 again.
- R3: Mode 0 (register direct) and mode 7 (reserved) set `no_mem`=1, `wb_en`=0 and `ea`=0.
- R4: Mode 1 (register indirect) gives `ea` = low 24 bits of `areg`, with `wb_en`=0.
- R5: Mode 2 (post-increment) gives `ea` = low 24 bits of `areg`, `areg_new` = `areg` + step and `wb_en`=1.
- R6: Mode 3 (pre-decrement) gives `areg_new` = `areg` - step, `ea` = low 24 bits of `areg_new` and `wb_en`=1.
- R7: The step is 1 for size 0 (byte), 2 for size 1 (word) and 4 for size 2 or 3 (long).
- R8: Mode 4 gives `ea` = `areg` + sign-extended `disp16`, with `wb_en`=0. A displacement of FFFF subtracts one.
- R9: Mode 5 gives `ea` = `areg` + sign-extended `disp8` + index. With `idx_long`=0 the index is the sign-extended low 16 bits of `xreg`. With `idx_long`=1 it is all 32 bits. Example: `areg`=00002004, `xreg` low word 0005, `disp8`=03 gives 00200C.
- R10: Mode 6 gives `ea` = low 24 bits of `abs_addr`, with `wb_en`=0.
- R11: `ea` is always the low 24 bits of the 32-bit sum, so carries above bit 23 are dropped.
- R12: When `wb_en` is 0, `areg_new` equals the captured `areg`, and `no_mem` is 0 for every mode except 0 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can take a request |
| mode | input | 3 | Addressing-mode code |
| size | input | 2 | Operand size: 0 byte, 1 word, 2/3 long |
| idx_long | input | 1 | Index width select: 0 word, 1 long |
| areg | input | 32 | Address-register value |
| xreg | input | 32 | Index-register value |
| disp16 | input | 16 | 16-bit displacement |
| disp8 | input | 8 | 8-bit displacement |
| abs_addr | input | 32 | Absolute address |
| out_valid | output | 1 | Result held and valid |
| out_ready | input | 1 | Consumer takes the result |
| ea | output | 24 | Effective address |
| areg_new | output | 32 | Updated address-register value |
| wb_en | output | 1 | Write `areg_new` back |
| no_mem | output | 1 | No memory access needed |

## Verification
The bench builds the block at its default widths: a 32-bit register path and a 24-bit address. At these widths the carry out of bit 23 and the sign-extension boundaries at 7F/80 and 7FFF/8000 can be reached with a handful of operand values. The bench sweeps every mode code, every size code and both index widths. It crosses them with register values near zero, near the 24-bit limit and at all ones, so wrap-around and negative offsets are covered in every mode. Some vectors stall the consumer so that the held result is seen across several cycles.

// File: rtl/addr_calc_pkg.sv
package addr_calc_pkg;
    typedef enum logic [2:0] {
        EM_REG_DIRECT = 3'd0,
        EM_INDIRECT   = 3'd1,
        EM_POST_INC   = 3'd2,
        EM_PRE_DEC    = 3'd3,
        EM_DISP16     = 3'd4,
        EM_INDEXED    = 3'd5,
        EM_ABSOLUTE   = 3'd6,
        EM_RESERVED   = 3'd7
    } ea_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } ctl_state_e;
endpackage

// File: rtl/addr_step_sel.sv
module addr_step_sel #(
    parameter int DATA_W = 32
) (
    input  logic [1:0]        size,
    output logic [DATA_W-1:0] step
);
    localparam logic [DATA_W-1:0] STEP_B = DATA_W'(1);
    localparam logic [DATA_W-1:0] STEP_W = DATA_W'(2);
    localparam logic [DATA_W-1:0] STEP_L = DATA_W'(4);

    always_comb begin
        if (size[1])
            step = STEP_L;
        else if (size[0])
            step = STEP_W;
        else
            step = STEP_B;
    end
endmodule

// File: rtl/addr_offset_ext.sv
module addr_offset_ext #(
    parameter int DATA_W = 32,
    parameter int D16_W  = 16,
    parameter int D8_W   = 8,
    parameter int IDXW_W = 16
) (
    input  logic [D16_W-1:0]  disp16,
    input  logic [D8_W-1:0]   disp8,
    input  logic [DATA_W-1:0] xreg,
    input  logic              idx_long,
    output logic [DATA_W-1:0] off_disp,
    output logic [DATA_W-1:0] off_index
);
    localparam int PAD16 = DATA_W - D16_W;
    localparam int PAD8  = DATA_W - D8_W;
    localparam int PADX  = DATA_W - IDXW_W;

    logic [DATA_W-1:0] d8_ext;
    logic [DATA_W-1:0] idx_val;

    always_comb begin
        off_disp  = {{PAD16{disp16[D16_W-1]}}, disp16};
        d8_ext    = {{PAD8{disp8[D8_W-1]}}, disp8};
        idx_val   = idx_long ? xreg
                             : {{PADX{xreg[IDXW_W-1]}}, xreg[IDXW_W-1:0]};
        off_index = d8_ext + idx_val;
    end
endmodule

// File: rtl/addr_ctrl_fsm.sv
module addr_ctrl_fsm
    import addr_calc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic out_ready,
    output logic in_ready,
    output logic out_valid,
    output logic load
);
    ctl_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid)  state_d = ST_HOLD;  // T_ACCEPT
            ST_HOLD: if (out_ready) state_d = ST_IDLE;  // T_RELEASE
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        load      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                in_ready = 1'b1;
                load     = in_valid;
            end
            ST_HOLD: out_valid = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/addr_calc_unit.sv
module addr_calc_unit
    import addr_calc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [2:0]        mode,
    input  logic [1:0]        size,
    input  logic              idx_long,
    input  logic [DATA_W-1:0] areg,
    input  logic [DATA_W-1:0] xreg,
    input  logic [15:0]       disp16,
    input  logic [7:0]        disp8,
    input  logic [DATA_W-1:0] abs_addr,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] ea,
    output logic [DATA_W-1:0] areg_new,
    output logic              wb_en,
    output logic              no_mem
);
    logic [DATA_W-1:0] step;
    logic [DATA_W-1:0] off_disp;
    logic [DATA_W-1:0] off_index;
    logic              load;

    logic [DATA_W-1:0] sum_d;
    logic [DATA_W-1:0] anew_d;
    logic              wb_d;
    logic              nm_d;
    ea_mode_e          mode_e;

    addr_step_sel #(.DATA_W(DATA_W)) u_step (
        .size (size),
        .step (step)
    );

    addr_offset_ext #(
        .DATA_W (DATA_W),
        .D16_W  (16),
        .D8_W   (8),
        .IDXW_W (16)
    ) u_off (
        .disp16    (disp16),
        .disp8     (disp8),
        .xreg      (xreg),
        .idx_long  (idx_long),
        .off_disp  (off_disp),
        .off_index (off_index)
    );

    addr_ctrl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .load      (load)
    );

    always_comb begin
        mode_e = ea_mode_e'(mode);
        sum_d  = '0;
        anew_d = areg;
        wb_d   = 1'b0;
        nm_d   = 1'b0;
        unique case (mode_e)
            EM_REG_DIRECT, EM_RESERVED: nm_d = 1'b1;
            EM_INDIRECT:  sum_d = areg;
            EM_POST_INC: begin
                sum_d  = areg;
                anew_d = areg + step;
                wb_d   = 1'b1;
            end
            EM_PRE_DEC: begin
                anew_d = areg - step;
                sum_d  = anew_d;
                wb_d   = 1'b1;
            end
            EM_DISP16:   sum_d = areg + off_disp;
            EM_INDEXED:  sum_d = areg + off_index;
            EM_ABSOLUTE: sum_d = abs_addr;
            default:     nm_d  = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea       <= '0;
            areg_new <= '0;
            wb_en    <= 1'b0;
            no_mem   <= 1'b0;
        end else if (load) begin
            ea       <= sum_d[ADDR_W-1:0];
            areg_new <= anew_d;
            wb_en    <= wb_d;
            no_mem   <= nm_d;
        end
    end
endmodule

// File: rtl/addr_calc_chk.sv
module addr_calc_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [ADDR_W-1:0] ea,
    input logic [DATA_W-1:0] areg_new,
    input logic              wb_en,
    input logic              no_mem
);
    // R2
    accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(in_valid && in_ready));

    // R2
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(ea) && $stable(areg_new)
                                       && $stable(wb_en) && $stable(no_mem)));

    // R2
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    // R3
    no_mem_zero_ea_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && no_mem) |-> (ea == '0 && !wb_en));

    // R12
    wb_has_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && wb_en) |-> !no_mem);

    // R2
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=> !out_valid);
endmodule

bind addr_calc_unit addr_calc_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .ea        (ea),
    .areg_new  (areg_new),
    .wb_en     (wb_en),
    .no_mem    (no_mem)
);

// File: tb/sim_addr_calc_unit.sv
module sim_addr_calc_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [2:0]  mode = '0;
    logic [1:0]  size = '0;
    logic        idx_long = 1'b0;
    logic [31:0] areg = '0;
    logic [31:0] xreg = '0;
    logic [15:0] disp16 = '0;
    logic [7:0]  disp8 = '0;
    logic [31:0] abs_addr = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [23:0] ea;
    logic [31:0] areg_new;
    logic        wb_en;
    logic        no_mem;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    addr_calc_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .mode(mode), .size(size), .idx_long(idx_long), .areg(areg), .xreg(xreg),
        .disp16(disp16), .disp8(disp8), .abs_addr(abs_addr),
        .out_valid(out_valid), .out_ready(out_ready), .ea(ea),
        .areg_new(areg_new), .wb_en(wb_en), .no_mem(no_mem)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic string tag_of(input int m);
        case (m)
            0, 7: return "R3";
            1: return "R4";
            2: return "R5/R7";
            3: return "R6/R7";
            4: return "R8/R11";
            5: return "R9/R11";
            default: return "R10";
        endcase
    endfunction

    task automatic run_vec(input int m, input int sz, input bit il, input logic [31:0] a,
                           input logic [31:0] x, input logic [15:0] d16, input logic [7:0] d8,
                           input logic [31:0] ab, input int stall);
        logic [31:0] stp, e32, an;
        bit ewb, enm;
        stp = (sz >= 2) ? 32'd4 : (sz == 1) ? 32'd2 : 32'd1;
        an = a; ewb = 0; enm = 0; e32 = 0;
        case (m)
            1: e32 = a;
            2: begin e32 = a; an = a + stp; ewb = 1; end
            3: begin an = a - stp; e32 = an; ewb = 1; end
            4: e32 = a + {{16{d16[15]}}, d16};
            5: e32 = a + {{24{d8[7]}}, d8} + (il ? x : {{16{x[15]}}, x[15:0]});
            6: e32 = ab;
            default: enm = 1;
        endcase
        @(negedge clk);
        mode = 3'(m); size = 2'(sz); idx_long = il; areg = a; xreg = x;
        disp16 = d16; disp8 = d8; abs_addr = ab; in_valid = 1'b1;
        check(in_ready == 1'b1, "R2 ready", 64'(in_ready), 64'd1);
        @(negedge clk);
        in_valid = 1'b0;
        for (int s = 0; s <= stall; s++) begin
            if (s > 0) @(negedge clk);
            check(out_valid && !in_ready, "R2 held", {62'd0, out_valid, in_ready}, 64'd2);
            check(ea == e32[23:0] && no_mem == enm && wb_en == ewb && areg_new == an,
                  tag_of(m), {4'd0, ea, areg_new, 2'd0, wb_en, no_mem},
                  {4'd0, e32[23:0], an, 2'd0, ewb, enm});
        end
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        check(!out_valid && in_ready, "R2 release", {62'd0, out_valid, in_ready}, 64'd1);
    endtask

    initial begin
        logic [31:0] av [5];
        logic [15:0] dv [4];
        logic [7:0]  bv [4];
        logic [31:0] xv [4];
        av[0] = 32'h0000_2004; av[1] = 32'h00FF_FFFE; av[2] = 32'hFFFF_FFFF;
        av[3] = 32'h0000_0000; av[4] = 32'h1234_5678;
        dv[0] = 16'h0000; dv[1] = 16'hFFFF; dv[2] = 16'h7FFF; dv[3] = 16'h8000;
        bv[0] = 8'h03; bv[1] = 8'hFF; bv[2] = 8'h80; bv[3] = 8'h7F;
        xv[0] = 32'h100A_0005; xv[1] = 32'h1266_FFFF; xv[2] = 32'h8000_8000; xv[3] = 32'h7FFF_0001;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(out_valid == 1'b0 && in_ready == 1'b1, "R1", {62'd0, out_valid, in_ready}, 64'd1);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0 && in_ready == 1'b1, "R1", {62'd0, out_valid, in_ready}, 64'd1);
        // R9 worked example
        run_vec(5, 1, 1'b0, 32'h0000_2004, 32'h100A_0005, 16'h0, 8'h03, 32'h0, 2);
        check(ea == 24'h00200C, "R9 example", 64'(ea), 64'h00200C);
        for (int m = 0; m < 8; m++)
            for (int sz = 0; sz < 4; sz++)
                for (int il = 0; il < 2; il++)
                    for (int ai = 0; ai < 5; ai++)
                        for (int di = 0; di < 4; di++)
                            run_vec(m, sz, il[0], av[ai], xv[di], dv[di], bv[di],
                                    av[ai] ^ {dv[di], dv[di]}, (ai == 0 && di == 1) ? 3 : 0);
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule